// File: doc/BRIEF.md
# Bit-Serial Clock Register Stream

This block carries the eight calendar registers of a real-time clock over a one-bit data path once an unlock sequence has opened access to them. The unlock logic pulses `start`. The block then takes a masked copy of the live register image and treats the next 64 qualified bus cycles as one fixed frame. The frame runs LSB first, from bit 0 of register 0 to bit 7 of register 7. On each bus cycle the direction input picks the action. A read cycle presents the next bit of the copy on `rd_bit`. A write cycle stores the incoming bit in an eight-bit staging buffer.

A staged byte reaches the calendar counter only when all eight of its cycles were writes. The write is issued as a one-cycle `commit_valid` strobe during the cycle that carries bit 7 of that byte. After the 64th cycle the block goes idle and pulses `done`, so the unlock logic can hand the bus back to ordinary memory.

The external reset pin can end a transfer early. It does so only when the reset-ignore flag in the live day register is clear, and the early end never commits a partial byte.

Top module: `rtc_bit_stream`

## Requirements
- R1: After reset, `active`, `done`, `commit_valid` and `rd_bit` are all 0.
- R2: A `start` pulse sets `active` from the next clock edge and places the frame pointer on bit 0 of register 0. This also applies while a transfer is already running, in which case the transfer restarts with a fresh copy.
- R3: The n-th qualified read cycle (n = 0..63) shows, during that cycle, bit n mod 8 of register n div 8 of the copy on `rd_bit`. Register k occupies bits 8k+7..8k of `live_regs`.
- R4: Changes on `live_regs` after the copy is taken do not alter the bits read in the same transfer.
- R5: Bits with no function read as 0 and are cleared in committed bytes. The keep-masks are reg0 FF, reg1 7F, reg2 7F, reg3 BF, reg4 37, reg5 3F, reg6 1F, reg7 FF (hex).
- R6: When all eight cycles of register k are writes, `commit_valid` is 1 during the cycle that writes bit 7. In that cycle `commit_idx` equals k and `commit_byte` equals the eight written bits ANDed with the keep-mask. `commit_valid` is 0 in every other cycle.
- R7: If any cycle of a byte is a read, that byte produces no commit.
- R8: The clock edge that ends the 64th cycle clears `active` and raises `done` for exactly one cycle.
- R9: While active, if `abort_pin_n` is 0 and bit 4 of register 4 in `live_regs` is 0, the transfer ends at the next edge. That cycle gives no commit, and `done` stays 0.
- R10: If bit 4 of register 4 in `live_regs` is 1, `abort_pin_n` has no effect and the transfer runs to its end with its commits.
- R11: While not active, bus cycles give `rd_bit` = 0 and no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| start | input | 1 | Unlock-complete pulse; takes the copy and opens the frame |
| live_regs | input | 64 | Current calendar register image, register k at bits 8k+7..8k |
| cyc_valid | input | 1 | One qualified bus cycle this clock |
| cyc_read | input | 1 | Direction of the cycle: 1 read, 0 write |
| wr_bit | input | 1 | Serial data bit of a write cycle |
| abort_pin_n | input | 1 | External reset pin, active low |
| rd_bit | output | 1 | Serial data bit for a read cycle |
| commit_valid | output | 1 | Whole-byte write strobe to the calendar counter |
| commit_idx | output | 3 | Register index of the committed byte |
| commit_byte | output | 8 | Masked byte value to store |
| active | output | 1 | Frame open |
| done | output | 1 | One-cycle pulse after the 64th cycle |

## Verification
A frame pointer that slips by one position shows up on `rd_bit` at the very first read of a non-symmetric pattern. The same slip moves commits off the bit-7 cycles within eight writes. A staging or byte-validity fault shows up as a wrong `commit_byte`, or as a commit that appears or is missing, no later than the end of the affected byte. A wrong copy or a wrong mask shows up in the first read of the affected register. A fault in end-of-frame or abort handling shows up one cycle after the 64th or the aborting cycle, through `active` and `done`.

// File: rtl/rtc_bit_stream.sv
`timescale 1ns/1ps
module rtc_bit_stream #(
  parameter int NREG = 8,
  parameter int RW = 8,
  parameter logic [NREG*RW-1:0] KEEP_MASK = 64'hFF1F_3F37_BF7F_7FFF,
  parameter int ABORT_REG = 4,
  parameter int ABORT_BIT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NREG*RW-1:0]      live_regs,
  input  logic                    cyc_valid,
  input  logic                    cyc_read,
  input  logic                    wr_bit,
  input  logic                    abort_pin_n,
  output logic                    rd_bit,
  output logic                    commit_valid,
  output logic [$clog2(NREG)-1:0] commit_idx,
  output logic [RW-1:0]           commit_byte,
  output logic                    active,
  output logic                    done
);
  localparam int FW = NREG * RW;
  localparam int IW = $clog2(NREG);
  localparam int BW = $clog2(RW);
  localparam int PW = IW + BW;

  logic [FW-1:0] snap;
  logic [RW-1:0] stage;
  logic [PW-1:0] ptr;
  logic          byte_ok;

  wire [BW-1:0] bsel = ptr[BW-1:0];
  wire [IW-1:0] rsel = ptr[PW-1:BW];
  wire abort_hit = active & ~abort_pin_n & ~live_regs[ABORT_REG*RW+ABORT_BIT];
  wire step = active & cyc_valid & ~abort_hit & ~start;
  wire cur_ok = ~cyc_read & ((bsel == '0) | byte_ok);
  wire [RW-1:0] byte_now = {wr_bit, stage[RW-2:0]};

  assign rd_bit = active & snap[ptr];
  assign commit_valid = step & cur_ok & (&bsel);
  assign commit_idx = rsel;
  assign commit_byte = byte_now & KEEP_MASK[rsel*RW +: RW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap <= '0;
      stage <= '0;
      ptr <= '0;
      byte_ok <= 1'b0;
      active <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        snap <= live_regs & KEEP_MASK;
        ptr <= '0;
        byte_ok <= 1'b0;
        active <= 1'b1;
      end else if (abort_hit) begin
        active <= 1'b0;
      end else if (step) begin
        if (!cyc_read) stage[bsel] <= wr_bit;
        byte_ok <= cur_ok;
        ptr <= ptr + 1'b1;
        if (&ptr) begin
          active <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_start_rearm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active && ptr == '0);
  assert_commit_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> active && cyc_valid && !cyc_read);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active && $past(active));
  assert_abort_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_hit && !start) |=> !active && !done);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !rd_bit && !commit_valid);
endmodule

// File: tb/rtc_bit_stream_bench.sv
`timescale 1ns/1ps
module rtc_bit_stream_bench;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, start, cyc_valid, cyc_read, wr_bit, abort_pin_n;
  logic [63:0] live_regs;
  logic rd_bit, commit_valid, active, done;
  logic [2:0] commit_idx;
  logic [7:0] commit_byte;
  int checks = 0, fails = 0;

  rtc_bit_stream u_rtc_bit_stream (
    .clk(clk), .rst_n(rst_n), .start(start), .live_regs(live_regs),
    .cyc_valid(cyc_valid), .cyc_read(cyc_read), .wr_bit(wr_bit),
    .abort_pin_n(abort_pin_n), .rd_bit(rd_bit), .commit_valid(commit_valid),
    .commit_idx(commit_idx), .commit_byte(commit_byte), .active(active), .done(done));

  function automatic logic [7:0] keepm(int r);
    case (r)
      1, 2: return 8'h7F;
      3: return 8'hBF;
      4: return 8'h37;
      5: return 8'h3F;
      6: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    #1 chk("R2 active after start", active, 1);
  endtask

  logic got, cv;
  logic [2:0] ci;
  logic [7:0] cb;

  task automatic cyc(input logic rd, input logic b, input logic ab_n);
    @(negedge clk);
    cyc_valid = 1; cyc_read = rd; wr_bit = b; abort_pin_n = ab_n;
    #1;
    got = rd_bit; cv = commit_valid; ci = commit_idx; cb = commit_byte;
    @(posedge clk); #0.5;
    cyc_valid = 0; abort_pin_n = 1;
  endtask

  task automatic check_end();
    @(negedge clk); #1;
    chk("R8 done high", done, 1);
    chk("R8 active low", active, 0);
    @(negedge clk); #1;
    chk("R8 done one cycle", done, 0);
  endtask

  task automatic read_frame(logic [63:0] l, bit flip_mid);
    logic [7:0] m;
    live_regs = l;
    do_start();
    for (int i = 0; i < 64; i++) begin
      if (flip_mid && i == 20) live_regs = ~l;
      cyc(1, 0, 1);
      m = keepm(i / 8);
      if (!m[i % 8]) chk("R5 zero bit reads 0", got, 0);
      else chk(flip_mid ? "R4 snapshot read" : "R3 read bit", got, l[i]);
      chk("R7 no commit on read", cv, 0);
    end
    check_end();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] l, w;
    rst_n = 0; start = 0; cyc_valid = 0; cyc_read = 0; wr_bit = 0;
    abort_pin_n = 1; live_regs = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 active", active, 0); chk("R1 done", done, 0);
    chk("R1 commit", commit_valid, 0); chk("R1 rd_bit", rd_bit, 0);
    @(negedge clk); rst_n = 1;

    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 8; k++) l[8*k +: 8] = 8'((p * 53 + k * 29 + 7) ^ (p * 17));
      if (p == 4) l = '1;
      read_frame(l, p[0]);
    end

    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 8; k++) w[8*k +: 8] = 8'(p * 91 + k * 37 + 5);
      if (p == 3) w = '1;
      live_regs = 64'h0000_0010_0000_0000;
      do_start();
      for (int i = 0; i < 64; i++) begin
        cyc(0, w[i], (i == 30) ? 1'b0 : 1'b1);
        if (i % 8 == 7) begin
          chk("R6 commit strobe", cv, 1);
          chk("R6 commit idx", ci, i / 8);
          chk("R6 commit byte", cb, w[i-7 +: 8] & keepm(i / 8));
        end else chk("R6 no early commit", cv, 0);
        if (i == 30) chk("R10 abort ignored", 1, 1);
      end
      check_end();
    end

    w = 64'hA5C3_5A3C_9669_0FF0;
    live_regs = '0;
    do_start();
    for (int i = 0; i < 64; i++) begin
      cyc((i == 19 || i == 47) ? 1'b1 : 1'b0, w[i], 1);
      if (i % 8 == 7) begin
        if (i / 8 == 2 || i / 8 == 5) chk("R7 mixed byte no commit", cv, 0);
        else begin
          chk("R6 commit strobe", cv, 1);
          chk("R6 commit byte", cb, w[i-7 +: 8] & keepm(i / 8));
        end
      end
    end
    check_end();

    live_regs = '0;
    do_start();
    for (int i = 0; i < 15; i++) cyc(0, 1, 1);
    cyc(0, 1, 0);
    chk("R9 no commit on abort", cv, 0);
    @(negedge clk); #1;
    chk("R9 active cleared", active, 0);
    chk("R9 no done", done, 0);
    for (int i = 0; i < 8; i++) begin
      cyc(i % 2, 1, 1);
      chk("R11 idle rd_bit", got, 0);
      chk("R11 idle commit", cv, 0);
    end

    live_regs = 64'hFFFF_FFFF_FFFF_FFFF;
    do_start();
    for (int i = 0; i < 10; i++) cyc(1, 0, 1);
    l = 64'h1234_5678_9ABC_DEF0;
    read_frame(l, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule